// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small 8-bit processor core and carries out the hardware part of taking and leaving an interrupt. At an instruction boundary it accepts the core's register snapshot. If a locally enabled request is pending and the global mask bit in the condition code byte is clear, or if a software interrupt is requested, it does three things. It writes a five-byte frame to a byte-wide stack memory and sets the mask bit. It then reads the two-byte handler address from a fixed vector table. On a return request it reads the frame back in reverse order, which restores the mask bit as it was saved.

After either sequence the block reads three program bytes starting at the new program counter and hands them to the core's instruction queue over a valid/ready stream. The updated register set is presented on the context outputs for one cycle with a load strobe. The core keeps the high byte of its index register itself, because the block never saves or restores it.

The memory port is synchronous. Read data is returned in the cycle after the read is issued, and a write completes at the clock edge. On the fetch stream, a byte is transferred in a cycle where `fq_valid` and `fq_ready` are both high. While `fq_ready` is low, `fq_valid` stays high and `fq_data` stays unchanged. The block issues no further memory access until the byte has been taken.

Top module: `ies_seq`

## Requirements
- R1: A sequence starts only in a cycle where `busy` is low and `instr_done` is high. An entry also needs either `swi_req` high, or at least one bit of `irq_pend` set while bit 3 (the mask bit) of `cpu_ccr` is 0. Pending requests with the mask set, or without `instr_done`, leave `busy` low and produce no memory access.
- R2: Entry writes five bytes at descending addresses. The low PC byte goes to `cpu_sp`, the high PC byte to `cpu_sp`-1, `cpu_x` to `cpu_sp`-2, `cpu_a` to `cpu_sp`-3, and the unmodified `cpu_ccr` to `cpu_sp`-4.
- R3: The stack pointer loaded after entry is `cpu_sp`-5. The stack pointer loaded after a return is `cpu_sp`+5.
- R4: An entry performs exactly five memory writes and a return performs none. The block has no index-high path, so only the 8-bit `cpu_x` is saved.
- R5: The condition code loaded after entry equals the saved `cpu_ccr` with bit 3 forced to 1.
- R6: The handler address for vector slot s is read with its high byte at address VEC_TOP-2s and its low byte at the next address (VEC_TOP = 0xFFFE). The loaded PC is {high, low}.
- R7: `irq_pend` bit j uses slot j+2, and the lowest set bit wins. A software interrupt uses slot 1 and beats every `irq_pend` bit.
- R8: A return reads the condition code from `cpu_sp`+1, then the accumulator from +2, the index low byte from +3, the PC high byte from +4 and the PC low byte from +5. The loaded condition code, including the mask bit, is the byte read back.
- R9: After entry or return, three bytes are read from PC, PC+1 and PC+2 and delivered in that order on the fetch stream. Each byte is held stable while `fq_ready` is low.
- R10: A software interrupt starts an entry even when the mask bit of `cpu_ccr` is 1.
- R11: `busy` rises in the cycle after the start and falls after the third fetch transfer. `instr_done` seen while `busy` is high starts nothing.
- R12: When `rti_req` and a qualified entry request arrive at the same boundary, the return is carried out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Current instruction has completed (boundary) |
| irq_pend | input | N_SRC | Pending, locally enabled requests; bit j uses slot j+2 |
| swi_req | input | 1 | Software interrupt at this boundary |
| rti_req | input | 1 | Return from interrupt at this boundary |
| cpu_pc | input | 16 | Address of the next unexecuted instruction |
| cpu_sp | input | 16 | Stack pointer (next free byte) |
| cpu_a | input | 8 | Accumulator |
| cpu_x | input | 8 | Index register low byte |
| cpu_ccr | input | 8 | Condition code byte; bit 3 is the mask |
| busy | output | 1 | A sequence is in progress |
| ctx_load | output | 1 | One-cycle strobe: core loads the ctx_* values |
| ctx_pc | output | 16 | New program counter |
| ctx_sp | output | 16 | New stack pointer |
| ctx_a | output | 8 | New accumulator |
| ctx_x | output | 8 | New index low byte |
| ctx_ccr | output | 8 | New condition code byte |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| fq_valid | output | 1 | Fetch byte available |
| fq_ready | input | 1 | Core instruction queue accepts the byte |
| fq_data | output | 8 | Fetched program byte |

## Verification
The assertions check, on every cycle, the following rules. Each push address sits one below the one before it. The two vector reads are an adjacent pair ending on an odd address. The mask bit is set in the context loaded after an entry. A stalled fetch byte holds still. Every rise of `busy` follows a qualified boundary, and the priority pick names a pending bit. The bench scenarios are needed to show the frame contents and their order, the final stack pointers, and which vector wins among several pending sources or a software interrupt. They also show that masked or busy-time requests leave no trace, and that a return restores the saved registers and mask.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 16;
  localparam int FRAME_LEN = 5;
  localparam int FETCH_LEN = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH, S_VEC, S_POP, S_SETTLE, S_FRD, S_FCAP, S_FOUT
  } seq_state_t;

  // pop order is the enum order: ccr, a, x, pc high, pc low
  typedef enum logic [2:0] {
    D_CCR, D_A, D_X, D_PCH, D_PCL
  } dst_t;
endpackage

// File: rtl/ies_prio.sv
module ies_prio #(
  parameter int N_SRC = 8,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |pend_i;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  // the chosen index must point at a set request
  always_comb begin
    if (any_o) begin
      assert_pick_pending_R7: assert (pend_i[idx_o])
        else $error("priority pick not pending");
    end
  end
endmodule

// File: rtl/ies_vec_addr.sv
module ies_vec_addr #(
  parameter int               SLOT_W  = 4,
  parameter logic [15:0]      VEC_TOP = 16'hFFFE
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic [15:0]       addr_o
);
  always_comb addr_o = VEC_TOP - (16'(slot_i) << 1);
endmodule

// File: rtl/ies_seq.sv
module ies_seq
  import ies_pkg::*;
#(
  parameter int          N_SRC    = 8,
  parameter logic [15:0] VEC_TOP  = 16'hFFFE,
  parameter int          MASK_BIT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_done,
  input  logic [N_SRC-1:0]    irq_pend,
  input  logic                swi_req,
  input  logic                rti_req,
  input  logic [ADDR_W-1:0]   cpu_pc,
  input  logic [ADDR_W-1:0]   cpu_sp,
  input  logic [BYTE_W-1:0]   cpu_a,
  input  logic [BYTE_W-1:0]   cpu_x,
  input  logic [BYTE_W-1:0]   cpu_ccr,
  output logic                busy,
  output logic                ctx_load,
  output logic [ADDR_W-1:0]   ctx_pc,
  output logic [ADDR_W-1:0]   ctx_sp,
  output logic [BYTE_W-1:0]   ctx_a,
  output logic [BYTE_W-1:0]   ctx_x,
  output logic [BYTE_W-1:0]   ctx_ccr,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                fq_valid,
  input  logic                fq_ready,
  output logic [BYTE_W-1:0]   fq_data
);
  localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int SLOT_W = $clog2(N_SRC + 2);
  localparam int CNT_W  = 3;
  localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_FETCH = CNT_W'(FETCH_LEN - 1);
  localparam logic [SLOT_W-1:0] SWI_SLOT  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SRC_BASE  = SLOT_W'(2);

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] pc_q, sp_q;
  logic [BYTE_W-1:0] a_q, x_q, ccr_q, fq_data_q;
  logic [SLOT_W-1:0] slot_q;
  logic              entry_q, rd_vld_q, load_q;
  dst_t              rd_dst_q, rd_dst_d;
  logic              rd_cap;

  logic              any_pend;
  logic [IDX_W-1:0]  pick_idx;
  logic [SLOT_W-1:0] start_slot;
  logic [ADDR_W-1:0] vec_base;
  logic              go_ret, go_ent;

  ies_prio #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i(irq_pend), .any_o(any_pend), .idx_o(pick_idx)
  );

  ies_vec_addr #(.SLOT_W(SLOT_W), .VEC_TOP(VEC_TOP)) u_vec (
    .slot_i(slot_q), .addr_o(vec_base)
  );

  always_comb begin
    start_slot = swi_req ? SWI_SLOT : SLOT_W'(pick_idx) + SRC_BASE;
    go_ret = (state_q == S_IDLE) && instr_done && rti_req;
    go_ent = (state_q == S_IDLE) && instr_done && !rti_req &&
             (swi_req || (any_pend && !cpu_ccr[MASK_BIT]));
  end

  // memory port drive per state
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    rd_cap    = 1'b0;
    rd_dst_d  = D_CCR;
    unique case (state_q)
      S_PUSH: begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = sp_q - ADDR_W'(cnt_q);
        unique case (cnt_q)
          3'd0:    mem_wdata = pc_q[7:0];
          3'd1:    mem_wdata = pc_q[15:8];
          3'd2:    mem_wdata = x_q;
          3'd3:    mem_wdata = a_q;
          default: mem_wdata = ccr_q;
        endcase
      end
      S_VEC: begin
        mem_en   = 1'b1;
        mem_addr = vec_base + ADDR_W'(cnt_q);
        rd_cap   = 1'b1;
        rd_dst_d = (cnt_q == '0) ? D_PCH : D_PCL;
      end
      S_POP: begin
        mem_en   = 1'b1;
        mem_addr = sp_q + ADDR_W'(cnt_q) + ADDR_W'(1);
        rd_cap   = 1'b1;
        rd_dst_d = dst_t'(cnt_q);
      end
      S_FRD: begin
        mem_en   = 1'b1;
        mem_addr = pc_q + ADDR_W'(cnt_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      pc_q      <= '0;
      sp_q      <= '0;
      a_q       <= '0;
      x_q       <= '0;
      ccr_q     <= '0;
      slot_q    <= '0;
      entry_q   <= 1'b0;
      rd_vld_q  <= 1'b0;
      rd_dst_q  <= D_CCR;
      load_q    <= 1'b0;
      fq_data_q <= '0;
    end else begin
      load_q   <= (state_q == S_SETTLE);
      rd_vld_q <= rd_cap;
      rd_dst_q <= rd_dst_d;
      if (rd_vld_q) begin
        unique case (rd_dst_q)
          D_CCR:   ccr_q      <= mem_rdata;
          D_A:     a_q        <= mem_rdata;
          D_X:     x_q        <= mem_rdata;
          D_PCH:   pc_q[15:8] <= mem_rdata;
          default: pc_q[7:0]  <= mem_rdata;
        endcase
      end
      unique case (state_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (go_ret) begin
            sp_q    <= cpu_sp;
            entry_q <= 1'b0;
            state_q <= S_POP;
          end else if (go_ent) begin
            pc_q    <= cpu_pc;
            sp_q    <= cpu_sp;
            a_q     <= cpu_a;
            x_q     <= cpu_x;
            ccr_q   <= cpu_ccr;
            slot_q  <= start_slot;
            entry_q <= 1'b1;
            state_q <= S_PUSH;
          end
        end
        S_PUSH: begin
          if (cnt_q == LAST_FRAME) begin
            ccr_q[MASK_BIT] <= 1'b1;
            sp_q    <= sp_q - ADDR_W'(FRAME_LEN);
            cnt_q   <= '0;
            state_q <= S_VEC;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_VEC: begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_q   <= '0;
            state_q <= S_SETTLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_POP: begin
          if (cnt_q == LAST_FRAME) begin
            sp_q    <= sp_q + ADDR_W'(FRAME_LEN);
            cnt_q   <= '0;
            state_q <= S_SETTLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_SETTLE: begin
          cnt_q   <= '0;
          state_q <= S_FRD;
        end
        S_FRD:  state_q <= S_FCAP;
        S_FCAP: begin
          fq_data_q <= mem_rdata;
          state_q   <= S_FOUT;
        end
        default: begin
          if (fq_ready) begin
            if (cnt_q == LAST_FETCH) begin
              cnt_q   <= '0;
              state_q <= S_IDLE;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= S_FRD;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    busy     = (state_q != S_IDLE);
    ctx_load = load_q;
    ctx_pc   = pc_q;
    ctx_sp   = sp_q;
    ctx_a    = a_q;
    ctx_x    = x_q;
    ctx_ccr  = ccr_q;
    fq_valid = (state_q == S_FOUT);
    fq_data  = fq_data_q;
  end

  assert_push_descends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PUSH && cnt_q != '0) |-> mem_addr == ADDR_W'($past(mem_addr) - 1'b1))
    else $error("push address not descending");

  assert_vec_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_VEC && cnt_q == CNT_W'(1)) |->
      (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)) && mem_addr[0])
    else $error("vector bytes not an adjacent pair");

  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && entry_q) |-> ctx_ccr[MASK_BIT])
    else $error("mask bit clear after entry");

  assert_fetch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fq_valid && !fq_ready) |=> (fq_valid && $stable(fq_data)))
    else $error("fetch byte dropped under back-pressure");

  assert_start_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(instr_done))
    else $error("sequence began without a boundary");

  assert_entry_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && entry_q) |->
      $past(swi_req || ((|irq_pend) && !cpu_ccr[MASK_BIT])))
    else $error("unqualified entry");
endmodule

// File: tb/tb_ies_seq.sv
`timescale 1ns/1ps
module tb_ies_seq;
  localparam int N_SRC = 8;
  localparam logic [15:0] VEC_TOP = 16'hFFFE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_done = 0, swi_req = 0, rti_req = 0, fq_ready = 1;
  logic [N_SRC-1:0] irq_pend = '0;
  logic [15:0] cpu_pc = '0, cpu_sp = '0;
  logic [7:0]  cpu_a = '0, cpu_x = '0, cpu_ccr = '0;
  logic busy, ctx_load, mem_en, mem_we, fq_valid;
  logic [15:0] ctx_pc, ctx_sp, mem_addr;
  logic [7:0]  ctx_a, ctx_x, ctx_ccr, mem_wdata, fq_data;
  logic [7:0]  mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit stall = 0;

  always #4 clk = ~clk;

  ies_seq #(.N_SRC(N_SRC), .VEC_TOP(VEC_TOP), .MASK_BIT(3)) dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .irq_pend(irq_pend),
    .swi_req(swi_req), .rti_req(rti_req), .cpu_pc(cpu_pc), .cpu_sp(cpu_sp),
    .cpu_a(cpu_a), .cpu_x(cpu_x), .cpu_ccr(cpu_ccr), .busy(busy),
    .ctx_load(ctx_load), .ctx_pc(ctx_pc), .ctx_sp(ctx_sp), .ctx_a(ctx_a),
    .ctx_x(ctx_x), .ctx_ccr(ctx_ccr), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_data(fq_data)
  );

  // byte memory model
  logic [7:0] mem [logic [15:0]];
  function automatic logic [7:0] mrd(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= mrd(mem_addr);
    end
  end

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
  } wr_t;
  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] sp;
    logic [7:0]  a;
    logic [7:0]  x;
    logic [7:0]  ccr;
  } ctx_t;

  wr_t   exp_wr[$];
  ctx_t  exp_ctx[$];
  string exp_tag[$];
  logic [7:0] exp_fq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor, sampled away from the active edge
  wr_t  m_wr;
  ctx_t m_ctx;
  string m_tag;
  logic [7:0] m_fq;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en && mem_we) begin
        if (exp_wr.size() == 0) chk(0, "R4", "unexpected write", {16'h0, mem_addr}, 0);
        else begin
          m_wr = exp_wr.pop_front();
          chk(mem_addr == m_wr.a, "R2", "push address", {16'h0, mem_addr}, {16'h0, m_wr.a});
          chk(mem_wdata == m_wr.d, "R2", "push data", {24'h0, mem_wdata}, {24'h0, m_wr.d});
        end
      end
      if (ctx_load) begin
        if (exp_ctx.size() == 0) chk(0, "R11", "unexpected context load", {16'h0, ctx_pc}, 0);
        else begin
          m_ctx = exp_ctx.pop_front();
          m_tag = exp_tag.pop_front();
          chk(ctx_pc == m_ctx.pc, m_tag, "pc", {16'h0, ctx_pc}, {16'h0, m_ctx.pc});
          chk(ctx_sp == m_ctx.sp, "R3", "sp", {16'h0, ctx_sp}, {16'h0, m_ctx.sp});
          chk(ctx_a == m_ctx.a, "R8", "a", {24'h0, ctx_a}, {24'h0, m_ctx.a});
          chk(ctx_x == m_ctx.x, "R8", "x", {24'h0, ctx_x}, {24'h0, m_ctx.x});
          chk(ctx_ccr == m_ctx.ccr, "R5", "ccr", {24'h0, ctx_ccr}, {24'h0, m_ctx.ccr});
        end
      end
      if (fq_valid && fq_ready) begin
        if (exp_fq.size() == 0) chk(0, "R9", "unexpected fetch byte", {24'h0, fq_data}, 0);
        else begin
          m_fq = exp_fq.pop_front();
          chk(fq_data == m_fq, "R9", "fetch byte", {24'h0, fq_data}, {24'h0, m_fq});
        end
      end
    end
  end

  // ready driver with optional back-pressure
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #2;
      k++;
      fq_ready = !stall || (k % 3 == 0);
    end
  end

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 200) begin
      @(posedge clk); #2;
      n++;
    end
    chk(!busy, req, "busy falls", {31'h0, busy}, 0);
    chk(exp_wr.size() == 0, "R4", "writes outstanding", exp_wr.size(), 0);
    chk(exp_fq.size() == 0, "R11", "fetch bytes outstanding before idle", exp_fq.size(), 0);
    chk(exp_ctx.size() == 0, req, "context outstanding", exp_ctx.size(), 0);
  endtask

  task automatic do_entry(input logic [N_SRC-1:0] pend, input bit swi,
                          input logic [7:0] ccr, input logic [15:0] pc,
                          input logic [7:0] a, input logic [7:0] x,
                          input logic [15:0] sp, input int slot, input string tag);
    logic [15:0] va, npc;
    ctx_t c;
    va  = VEC_TOP - 16'(2 * slot);
    npc = {mrd(va), mrd(va + 16'd1)};
    exp_wr.push_back('{a: sp,          d: pc[7:0]});
    exp_wr.push_back('{a: sp - 16'd1,  d: pc[15:8]});
    exp_wr.push_back('{a: sp - 16'd2,  d: x});
    exp_wr.push_back('{a: sp - 16'd3,  d: a});
    exp_wr.push_back('{a: sp - 16'd4,  d: ccr});
    c = '{pc: npc, sp: sp - 16'd5, a: a, x: x, ccr: ccr | 8'h08};
    exp_ctx.push_back(c);
    exp_tag.push_back(tag);
    for (int k = 0; k < 3; k++) exp_fq.push_back(mrd(npc + 16'(k)));
    @(posedge clk); #2;
    irq_pend = pend; swi_req = swi; cpu_ccr = ccr; cpu_pc = pc;
    cpu_a = a; cpu_x = x; cpu_sp = sp; instr_done = 1;
    @(posedge clk); #2;
    instr_done = 0; swi_req = 0; irq_pend = '0;
    chk(busy, "R11", "busy after start", {31'h0, busy}, 1);
  endtask

  task automatic do_return(input logic [15:0] sp, input logic [N_SRC-1:0] pend,
                           input logic [7:0] ccr, input string tag);
    ctx_t c;
    logic [15:0] npc;
    npc = {mrd(sp + 16'd4), mrd(sp + 16'd5)};
    c = '{pc: npc, sp: sp + 16'd5, a: mrd(sp + 16'd2), x: mrd(sp + 16'd3),
          ccr: mrd(sp + 16'd1)};
    exp_ctx.push_back(c);
    exp_tag.push_back(tag);
    for (int k = 0; k < 3; k++) exp_fq.push_back(mrd(npc + 16'(k)));
    @(posedge clk); #2;
    cpu_sp = sp; irq_pend = pend; cpu_ccr = ccr; rti_req = 1; instr_done = 1;
    @(posedge clk); #2;
    instr_done = 0; rti_req = 0; irq_pend = '0;
    chk(busy, "R11", "busy after return start", {31'h0, busy}, 1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    chk(!busy, "R11", "reset busy", {31'h0, busy}, 0);
    chk(!fq_valid, "R9", "reset fq_valid", {31'h0, fq_valid}, 0);
    chk(!mem_en, "R4", "reset mem_en", {31'h0, mem_en}, 0);
    chk(!ctx_load, "R11", "reset ctx_load", {31'h0, ctx_load}, 0);
    rst_n = 1;

    // R1: masked request at a boundary does nothing
    @(posedge clk); #2;
    irq_pend = 8'h04; cpu_ccr = 8'h08; instr_done = 1;
    @(posedge clk); #2;
    instr_done = 0;
    for (int k = 0; k < 4; k++) begin
      chk(!busy, "R1", "masked request ignored", {31'h0, busy}, 0);
      @(posedge clk); #2;
    end
    // R1: unmasked request without boundary does nothing
    cpu_ccr = 8'h00;
    for (int k = 0; k < 4; k++) begin
      chk(!busy, "R1", "no boundary, no start", {31'h0, busy}, 0);
      @(posedge clk); #2;
    end
    irq_pend = '0;

    // R2 R3 R5 R6: single source, bit 3 -> slot 5
    do_entry(8'h08, 0, 8'h00, 16'h8123, 8'h11, 8'h22, 16'h01F0, 5, "R6");
    wait_idle("R6");

    // R7: several sources, lowest set bit 2 -> slot 4
    do_entry(8'b1001_0100, 0, 8'h01, 16'h9456, 8'h33, 8'h44, 16'h01E0, 4, "R7");
    wait_idle("R7");

    // R10: software interrupt with mask set and a pending source -> slot 1
    do_entry(8'h01, 1, 8'h08, 16'hA789, 8'h55, 8'h66, 16'h01D0, 1, "R10");
    wait_idle("R10");

    // R8: return from first frame with back-pressure on the fetch stream
    stall = 1;
    do_return(16'h01EB, '0, 8'h08, "R8");
    wait_idle("R8");
    chk(ctx_ccr[3] == 1'b0, "R8", "mask restored clear", {31'h0, ctx_ccr[3]}, 0);
    stall = 0;

    // R12: return and qualified request together -> return wins
    do_return(16'h01DB, 8'h02, 8'h00, "R12");
    wait_idle("R12");

    // R11: boundary during a sequence is ignored
    do_entry(8'h80, 0, 8'h00, 16'h7001, 8'h77, 8'h88, 16'h0180, 9, "R11");
    repeat (2) @(posedge clk);
    #2;
    rti_req = 1; swi_req = 1; instr_done = 1;
    @(posedge clk); #2;
    rti_req = 0; swi_req = 0; instr_done = 0;
    wait_idle("R11");
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      chk(!busy, "R11", "stays idle after busy-time boundary", {31'h0, busy}, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule